// File: doc/BRIEF.md
# Page-Splitting Flash Program Sequencer

This block takes one write request, given as a 24-bit start address and a byte count, and turns it into a series of page-program operations for a serial NOR flash. No operation crosses a page boundary. The first chunk runs from the start address up to the end of its page. The chunks after it are full pages, and the last one carries whatever is left. The sequencer does not drive the serial pins. It starts a command-frame engine and a status poller, and each of them answers with a one-cycle done pulse and a fail flag.

Each chunk runs a fixed sequence:

1. A write-enable command.
2. A poll until the write-enable latch reads set.
3. The program command. While it runs, the engine pulls bytes one at a time through the sequencer from a byte FIFO.
4. A poll until the write-in-progress bit clears.

A failure at any step ends the whole request with an error pulse. A request of zero bytes finishes at once with a done pulse. A request that would run past the end of the device is rejected before any command is issued.

Top module: `flash_page_writer`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `cmd_start`, `poll_start` and `fifo_rd` are all low.
- R2: A request with `req_len` = 0 raises `done` for one cycle, in the cycle after the request is accepted. No command or poll is started.
- R3: A request with `req_addr + req_len` greater than 2^ADDR_W raises `err` for one cycle, in the cycle after acceptance, and starts nothing. A request that ends exactly at 2^ADDR_W is accepted.
- R4: The first program command has address `req_addr` and length `min(PAGE_BYTES - (req_addr mod PAGE_BYTES), req_len)`.
- R5: Each later program command starts at the previous address plus the previous length. Its length is PAGE_BYTES, or the remaining count if that is smaller. No program command spans two pages.
- R6: For every chunk the block issues, in this order: a command with `cmd_prog`=0 (write enable), a poll with `poll_wip`=0 (wait for the latch), a command with `cmd_prog`=1 (program), and a poll with `poll_wip`=1 (wait until not busy). Nothing overlaps.
- R7: After the final not-busy poll succeeds, `done` pulses for one cycle and `busy` is low in that same cycle. `done` and `err` are never high together.
- R8: `cmd_fail` or `poll_fail`, when it arrives with its done pulse, aborts the request with an `err` pulse. No further command or poll is started.
- R9: `fifo_rd` is high only when the engine takes a byte (`byte_take`) during a program command and the FIFO is not empty. `byte_out` carries `fifo_data`. A take while the FIFO is empty aborts with `err`.
- R10: The engine must take exactly the chunk length of bytes. A take beyond the chunk length aborts at once. A program done with fewer bytes taken aborts with `err`.
- R11: `req_start` while `busy` is high is ignored. The running request completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Starts a request when the block is idle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Byte count |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is rejected or aborted |
| cmd_start | output | 1 | One-cycle launch of a command frame |
| cmd_prog | output | 1 | 1 = program command, 0 = write enable |
| cmd_addr | output | ADDR_W | Address for the program command |
| cmd_len | output | log2(PAGE_BYTES)+1 | Program byte count (0 for write enable) |
| cmd_done | input | 1 | Command frame finished |
| cmd_fail | input | 1 | Command frame failed (valid with cmd_done) |
| byte_take | input | 1 | Engine takes one data byte this cycle |
| byte_out | output | 8 | Data byte passed to the engine |
| poll_start | output | 1 | One-cycle launch of a status poll |
| poll_wip | output | 1 | 1 = wait for the busy bit to clear, 0 = wait for the write-enable latch to set |
| poll_done | input | 1 | Poll finished |
| poll_fail | input | 1 | Poll failed or timed out (valid with poll_done) |
| fifo_rd | output | 1 | Pops one byte from the FIFO |
| fifo_data | input | 8 | FIFO head byte |
| fifo_empty | input | 1 | FIFO holds no data |

## Verification
The assertions check four properties on every cycle:

- Commands and polls never launch together.
- No program command is launched without a successful latch poll since the last command.
- No program command crosses a page.
- The FIFO is never popped while it is empty, `done` and `err` stay exclusive, and the block is idle whenever either of them pulses.

Only the bench scenarios can show the rest. They check the exact chunk addresses and lengths for unaligned, aligned, single-byte and end-of-device requests. They confirm that every byte reaches the engine in order. They also check the response to injected command and poll failures, a FIFO underrun, a short or long byte count, and a request arriving while busy.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int LEN_W     = ADDR_W + 1,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CL_W      = PG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cmd_start,
  output logic              cmd_prog,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CL_W-1:0]   cmd_len,
  input  logic              cmd_done,
  input  logic              cmd_fail,
  input  logic              byte_take,
  output logic [7:0]        byte_out,
  output logic              poll_start,
  output logic              poll_wip,
  input  logic              poll_done,
  input  logic              poll_fail,
  output logic              fifo_rd,
  input  logic [7:0]        fifo_data,
  input  logic              fifo_empty
);

  localparam logic [LEN_W:0] DEV_END = (LEN_W+1)'(1) << ADDR_W;

  typedef enum logic [3:0] {
    S_IDLE, S_WEN_GO, S_WEN_WT, S_WEL_GO, S_WEL_WT,
    S_PRG_GO, S_PRG_WT, S_WIP_GO, S_WIP_WT
  } state_t;

  state_t            state;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [CL_W-1:0]   sent;

  logic [CL_W-1:0]   room;
  logic [CL_W-1:0]   chunk;
  logic [LEN_W:0]    req_end;
  logic              take_ok, underrun, overtake;
  logic [CL_W-1:0]   sent_nx;

  assign room     = CL_W'(PAGE_BYTES) - {1'b0, cur_addr[PG_W-1:0]};
  assign chunk    = (remain < LEN_W'(room)) ? remain[CL_W-1:0] : room;
  assign req_end  = {1'b0, LEN_W'(req_addr)} + {1'b0, req_len};

  assign take_ok  = (state == S_PRG_WT) && byte_take;
  assign fifo_rd  = take_ok && !fifo_empty && (sent != chunk);
  assign underrun = take_ok && fifo_empty;
  assign overtake = take_ok && (sent == chunk);
  assign sent_nx  = sent + CL_W'(fifo_rd);
  assign byte_out = fifo_data;

  assign busy       = (state != S_IDLE);
  assign cmd_start  = (state == S_WEN_GO) || (state == S_PRG_GO);
  assign cmd_prog   = (state == S_PRG_GO) || (state == S_PRG_WT);
  assign cmd_addr   = cur_addr;
  assign cmd_len    = cmd_prog ? chunk : '0;
  assign poll_start = (state == S_WEL_GO) || (state == S_WIP_GO);
  assign poll_wip   = (state == S_WIP_GO) || (state == S_WIP_WT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      sent     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        S_IDLE: if (req_start) begin
          if (req_len == '0) begin
            done <= 1'b1;
          end else if (req_end > DEV_END) begin
            err <= 1'b1;
          end else begin
            cur_addr <= req_addr;
            remain   <= req_len;
            state    <= S_WEN_GO;
          end
        end
        S_WEN_GO: state <= S_WEN_WT;
        S_WEN_WT: if (cmd_done) begin
          if (cmd_fail) begin err <= 1'b1; state <= S_IDLE; end
          else state <= S_WEL_GO;
        end
        S_WEL_GO: state <= S_WEL_WT;
        S_WEL_WT: if (poll_done) begin
          if (poll_fail) begin err <= 1'b1; state <= S_IDLE; end
          else begin sent <= '0; state <= S_PRG_GO; end
        end
        S_PRG_GO: state <= S_PRG_WT;
        S_PRG_WT: begin
          sent <= sent_nx;
          if (underrun || overtake) begin
            err <= 1'b1; state <= S_IDLE;
          end else if (cmd_done) begin
            if (cmd_fail || sent_nx != chunk) begin err <= 1'b1; state <= S_IDLE; end
            else state <= S_WIP_GO;
          end
        end
        S_WIP_GO: state <= S_WIP_WT;
        S_WIP_WT: if (poll_done) begin
          if (poll_fail) begin
            err <= 1'b1; state <= S_IDLE;
          end else begin
            cur_addr <= cur_addr + ADDR_W'(chunk);
            remain   <= remain - LEN_W'(chunk);
            if (remain == LEN_W'(chunk)) begin done <= 1'b1; state <= S_IDLE; end
            else state <= S_WEN_GO;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_page_writer_chk.sv
module flash_page_writer_chk #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int CL_W      = PG_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              cmd_start,
  input logic              cmd_prog,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CL_W-1:0]   cmd_len,
  input logic              poll_start,
  input logic              poll_wip,
  input logic              poll_done,
  input logic              poll_fail,
  input logic              fifo_rd,
  input logic              fifo_empty
);

  logic latch_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_ok <= 1'b0;
    else if (cmd_start) latch_ok <= 1'b0;
    else if (busy && poll_done && !poll_fail && !poll_wip) latch_ok <= 1'b1;
  end

  assert_single_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !poll_start);

  assert_latch_before_prog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_prog) |-> latch_ok);

  assert_page_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_prog) |->
      (cmd_len != '0 && (int'(cmd_addr[PG_W-1:0]) + int'(cmd_len)) <= PAGE_BYTES));

  assert_no_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  assert_end_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !busy);

  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !(cmd_start || poll_start));

endmodule

bind flash_page_writer flash_page_writer_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)
) chk_i (.*);

// File: tb/flash_page_writer_tb_top.sv
module flash_page_writer_tb_top;
  localparam int AW = 24;
  localparam int PG = 256;
  localparam int LW = AW + 1;
  localparam int CW = $clog2(PG) + 1;
  localparam int NV = 6;
  localparam logic [AW-1:0] V_ADDR [NV] = '{24'h000010, 24'h0000F0, 24'h000100,
                                            24'h0001FF, 24'h000000, 24'hFFFF80};
  localparam logic [LW-1:0] V_LEN  [NV] = '{25'd20, 25'd48, 25'd256,
                                            25'd600, 25'd1, 25'd128};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, req_start, busy, done, err;
  logic [AW-1:0] req_addr, cmd_addr;
  logic [LW-1:0] req_len;
  logic cmd_start, cmd_prog, cmd_done, cmd_fail, byte_take;
  logic [CW-1:0] cmd_len;
  logic [7:0] byte_out, fifo_data;
  logic poll_start, poll_wip, poll_done, poll_fail, fifo_rd, fifo_empty;

  flash_page_writer #(.ADDR_W(AW), .PAGE_BYTES(PG)) dut_i (.*);

  int checks = 0, fails = 0;
  int lg_kind [128];
  int lg_addr [128];
  int lg_len  [128];
  int n_log = 0, rx_cnt = 0, fifo_level = 100000, fifo_ptr = 0;
  int inj_log = -1, extra = 0;
  bit rx_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // command engine, poller and FIFO models
  initial begin
    bit c_pend = 0, p_pend = 0, took = 0;
    int c_bytes = 0, c_wait = 0, c_idx = 0, p_wait = 0, p_idx = 0;
    logic [7:0] seen = '0;
    cmd_done = 0; cmd_fail = 0; byte_take = 0; poll_done = 0; poll_fail = 0;
    fifo_data = '0; fifo_empty = 0;
    forever begin
      @(negedge clk);
      if (took) begin
        if (seen != 8'(rx_cnt)) rx_bad = 1;
        rx_cnt++; fifo_level--; fifo_ptr++;
      end
      fifo_data = 8'(fifo_ptr);
      fifo_empty = (fifo_level <= 0);
      cmd_done = 0; cmd_fail = 0; byte_take = 0; poll_done = 0; poll_fail = 0;
      if (c_pend) begin
        if (c_bytes > 0) begin byte_take = 1; c_bytes--; end
        else if (c_wait > 0) c_wait--;
        else begin cmd_done = 1; cmd_fail = (c_idx == inj_log); c_pend = 0; end
      end
      if (p_pend) begin
        if (p_wait > 0) p_wait--;
        else begin poll_done = 1; poll_fail = (p_idx == inj_log); p_pend = 0; end
      end
      if (cmd_start && n_log < 128) begin
        lg_kind[n_log] = cmd_prog ? 1 : 0;
        lg_addr[n_log] = int'(cmd_addr);
        lg_len[n_log]  = int'(cmd_len);
        c_pend = 1; c_idx = n_log; c_wait = 2;
        c_bytes = cmd_prog ? int'(cmd_len) + extra : 0;
        n_log++;
      end
      if (poll_start && n_log < 128) begin
        lg_kind[n_log] = poll_wip ? 3 : 2;
        lg_addr[n_log] = 0; lg_len[n_log] = 0;
        p_pend = 1; p_idx = n_log; p_wait = 3;
        n_log++;
      end
      #1;
      took = fifo_rd;
      seen = byte_out;
    end
  end

  task automatic prep(input int level);
    @(negedge clk); #2;
    n_log = 0; rx_cnt = 0; fifo_ptr = 0; rx_bad = 0; fifo_level = level;
  endtask

  task automatic kick(input logic [AW-1:0] a, input logic [LW-1:0] l);
    @(negedge clk); #2;
    req_addr = a; req_len = l; req_start = 1;
    @(negedge clk); #2;
    req_start = 0;
  endtask

  task automatic wait_end(output bit d, output bit e);
    int cyc = 0;
    while (!done && !err && cyc < 20000) begin
      @(negedge clk); #2; cyc++;
    end
    d = done; e = err;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic check_log(input int a0, input int l0, input string tag);
    int a = a0, r = l0, i = 0, bad = -1, c, first;
    first = (PG - a0 % PG < l0) ? PG - a0 % PG : l0;
    while (r > 0) begin
      c = (PG - a % PG < r) ? PG - a % PG : r;
      if (bad < 0 && (lg_kind[i] != 0 || lg_kind[i+1] != 2 || lg_kind[i+3] != 3)) bad = i;
      if (bad < 0 && (lg_kind[i+2] != 1 || lg_addr[i+2] != a || lg_len[i+2] != c)) bad = i + 2;
      a += c; r -= c; i += 4;
    end
    chk(lg_len[2] == first, "R4", {tag, " first chunk length"}, lg_len[2], first);
    chk(bad < 0, "R5", {tag, " chunk/order mismatch at log index"}, bad, -1);
    chk(n_log == i, "R6", {tag, " operation count"}, n_log, i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    checks++; fails++;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit d, e;
    rst_n = 0; req_start = 0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !done && !err, "R1", "idle outputs after reset", {busy, done, err}, 0);
    chk(!cmd_start && !poll_start && !fifo_rd, "R1", "no launch in reset",
        {cmd_start, poll_start, fifo_rd}, 0);
    rst_n = 1;
    idle_wait(2);
    chk(!busy && !cmd_start && !poll_start, "R1", "idle after release",
        {busy, cmd_start, poll_start}, 0);

    // table-driven normal requests
    for (int v = 0; v < NV; v++) begin
      prep(100000);
      kick(V_ADDR[v], V_LEN[v]);
      wait_end(d, e);
      chk(d && !e, "R7", $sformatf("vec%0d done without err", v), {d, e}, 2);
      chk(!busy, "R7", $sformatf("vec%0d idle at done", v), busy, 0);
      idle_wait(3);
      check_log(int'(V_ADDR[v]), int'(V_LEN[v]), $sformatf("vec%0d", v));
      chk(rx_cnt == int'(V_LEN[v]) && !rx_bad, "R9",
          $sformatf("vec%0d bytes delivered in order", v), rx_cnt, int'(V_LEN[v]));
    end

    // R2 zero length
    prep(100000);
    kick(24'h000123, '0);
    chk(done && !err && !busy, "R2", "zero length done next cycle", {done, err, busy}, 4);
    idle_wait(5);
    chk(n_log == 0, "R2", "zero length issues nothing", n_log, 0);

    // R3 range
    prep(100000);
    kick(24'hFFFF80, 25'h81);
    chk(err && !done, "R3", "past end rejected", {err, done}, 2);
    idle_wait(5);
    chk(n_log == 0, "R3", "rejected issues nothing", n_log, 0);
    prep(100000);
    kick(24'h000000, 25'h1FFFFFF);
    chk(err, "R3", "oversize count rejected", err, 1);

    // R8 command fail on second chunk program
    prep(100000); inj_log = 6;
    kick(24'h0000F0, 25'd48);
    wait_end(d, e);
    chk(e && !d, "R8", "program fail aborts", {d, e}, 1);
    idle_wait(40);
    chk(n_log == 7, "R8", "nothing after program fail", n_log, 7);

    // R8 poll fail on first latch poll
    prep(100000); inj_log = 1;
    kick(24'h000000, 25'd8);
    wait_end(d, e);
    chk(e && !d, "R8", "latch poll fail aborts", {d, e}, 1);
    idle_wait(40);
    chk(n_log == 2, "R8", "nothing after poll fail", n_log, 2);
    inj_log = -1;

    // R9 underrun
    prep(10);
    kick(24'h000000, 25'd20);
    wait_end(d, e);
    chk(e && !d, "R9", "empty FIFO take aborts", {d, e}, 1);
    chk(rx_cnt == 10, "R9", "bytes popped before underrun", rx_cnt, 10);
    idle_wait(40);

    // R10 short and long takes
    prep(100000); extra = -1;
    kick(24'h000000, 25'd12);
    wait_end(d, e);
    chk(e && !d, "R10", "short byte count aborts", {d, e}, 1);
    idle_wait(40);
    prep(100000); extra = 1;
    kick(24'h000000, 25'd12);
    wait_end(d, e);
    chk(e && !d, "R10", "excess byte take aborts", {d, e}, 1);
    chk(rx_cnt == 12, "R10", "popped bytes capped at chunk", rx_cnt, 12);
    idle_wait(40);
    extra = 0;

    // R11 request while busy ignored
    prep(100000);
    kick(24'h0001FF, 25'd600);
    idle_wait(5);
    req_addr = 24'hFFFFFF; req_len = 25'd0; req_start = 1;
    @(negedge clk); #2; req_start = 0;
    chk(!done && !err && busy, "R11", "busy request ignored", {done, err, busy}, 1);
    wait_end(d, e);
    chk(d && !e, "R11", "original request completes", {d, e}, 2);
    idle_wait(3);
    check_log(32'h1FF, 600, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule